// File: doc/BRIEF.md
# SCSI Transfer Offset and Gross-Error Monitor

This block watches the REQ and ACK strobes of a parallel SCSI bus during a transfer. It keeps a count of REQ pulses not yet answered by ACK. It raises sticky status bits when the handshake or the local data FIFO is misused. The raw bus strobes (REQ, ACK, ATN, active low on the wire) and the phase lines are synchronized into the core clock. Edges are found on the synchronized copies. The outstanding offset is compared against a programmable limit, and a mode input selects the initiator or the target check set.

The status byte also latches three single-cycle pulses from the surrounding sequencer: completion, selection and reselection. Selection and reselection only latch when their enable is high. Software reads the byte and clears it with a one-cycle read strobe. An interrupt line combines the latched bits with a per-bit mask.

Top module: `scsi_xfer_monitor`

## Requirements
- R1: After reset, `int_status` is 0x00, `irq` is 0 and the outstanding offset is zero.
- R2: The offset count rises by one on each REQ assertion and falls by one on each ACK assertion. It is unchanged when both assertions land in the same cycle, and it saturates at 0 and at 15.
- R3: In initiator mode (`is_initiator`=1), a REQ assertion while the count already equals or exceeds a nonzero `max_offset` sets bit 3. With `max_offset`=0 this check is off.
- R4: In target mode (`is_initiator`=0), an ACK assertion while the count is zero sets bit 3.
- R5: In initiator mode, a change of the synchronized phase lines while the count is nonzero sets bit 3. A change at count zero does not.
- R6: `fifo_rd` with `fifo_empty` high, or `fifo_wr` with `fifo_full` high, in the same cycle sets bit 3.
- R7: In initiator mode, bit 7 sets when the synchronized phase at a REQ assertion differs from `exp_phase`.
- R8: In target mode, bit 7 sets on an assertion of ATN.
- R9: A `done_pulse` sets bit 6.
- R10: `sel_pulse` sets bit 5 only when `sel_en` is high. `resel_pulse` sets bit 4 only when `resel_en` is high. Bits 2..0 read as zero.
- R11: Status bits stay set until `stat_rd` is high for a cycle. That read clears every bit except those whose event occurs in the same cycle.
- R12: `irq` is high exactly when some status bit and the matching `irq_mask` bit are both one.
- R13: A bus strobe is seen through two synchronizer flops. A REQ asserted on the wire before clock edge k shows in `int_status` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req_n | input | 1 | Raw REQ strobe, low = asserted |
| bus_ack_n | input | 1 | Raw ACK strobe, low = asserted |
| bus_atn_n | input | 1 | Raw ATN line, low = asserted |
| bus_phase | input | 3 | Raw bus phase lines |
| exp_phase | input | 3 | Phase the initiator expects |
| is_initiator | input | 1 | 1 = initiator checks, 0 = target checks |
| max_offset | input | 4 | Offset limit, 0 = asynchronous (no limit check) |
| fifo_rd | input | 1 | Data FIFO read strobe |
| fifo_wr | input | 1 | Data FIFO write strobe |
| fifo_empty | input | 1 | Data FIFO empty flag |
| fifo_full | input | 1 | Data FIFO full flag |
| done_pulse | input | 1 | Completion pulse |
| sel_pulse | input | 1 | Selection pulse |
| resel_pulse | input | 1 | Reselection pulse |
| sel_en | input | 1 | Allows bit 5 to latch |
| resel_en | input | 1 | Allows bit 4 to latch |
| stat_rd | input | 1 | Read-to-clear strobe |
| irq_mask | input | 8 | Per-bit interrupt enable |
| int_status | output | 8 | Sticky status byte |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench uses the default parameters: a 4-bit offset, three phase lines and two synchronizer stages. With these values the saturation point of 15 can be reached with seventeen REQ pulses, so the counter's upper bound can be tested directly. The two-stage latency is short enough to sample the exact cycle a bit appears. The saturated count is made visible at the ports: the bench walks the count back down with ACKs and then watches for the target-mode underflow.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  localparam int ST_W    = 8;
  localparam int B_PHASE = 7;
  localparam int B_DONE  = 6;
  localparam int B_SEL   = 5;
  localparam int B_RESEL = 4;
  localparam int B_GROSS = 3;

  // Saturating up/down step of the outstanding offset.
  function automatic int unsigned ofs_step(int unsigned cur, logic inc, logic dec,
                                           int unsigned top);
    if (inc && !dec) return (cur >= top) ? top : cur + 1;
    if (dec && !inc) return (cur == 0) ? 0 : cur - 1;
    return cur;
  endfunction

  // A new REQ would exceed a nonzero limit.
  function automatic logic exceeds_limit(int unsigned cur, int unsigned lim);
    return (lim != 0) && (cur >= lim);
  endfunction
endpackage

// File: rtl/xmon_sync.sv
module xmon_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] chain [0:STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/xmon_offset.sv
module xmon_offset import xmon_pkg::*; #(
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_rise,
  input  logic             ack_rise,
  input  logic             phase_chg,
  input  logic             is_initiator,
  input  logic [OFS_W-1:0] max_offset,
  output logic [OFS_W-1:0] ofs_cnt,
  output logic             ev_ovf,
  output logic             ev_udf,
  output logic             ev_phs
);
  localparam int unsigned OFS_TOP = (1 << OFS_W) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ofs_cnt <= '0;
    else        ofs_cnt <= OFS_W'(ofs_step(32'(ofs_cnt), req_rise, ack_rise, OFS_TOP));
  end

  assign ev_ovf = is_initiator & req_rise & ~ack_rise
                & exceeds_limit(32'(ofs_cnt), 32'(max_offset));
  assign ev_udf = ~is_initiator & ack_rise & ~req_rise & (ofs_cnt == '0);
  assign ev_phs = is_initiator & phase_chg & (ofs_cnt != '0);
endmodule

// File: rtl/xmon_status.sv
module xmon_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         rd,
  output logic [W-1:0] stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (rd ? '0 : stat) | ev;
  end
endmodule

// File: rtl/scsi_xfer_monitor.sv
module scsi_xfer_monitor import xmon_pkg::*; #(
  parameter int OFS_W   = 4,
  parameter int PHASE_W = 3,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req_n,
  input  logic               bus_ack_n,
  input  logic               bus_atn_n,
  input  logic [PHASE_W-1:0] bus_phase,
  input  logic [PHASE_W-1:0] exp_phase,
  input  logic               is_initiator,
  input  logic [OFS_W-1:0]   max_offset,
  input  logic               fifo_rd,
  input  logic               fifo_wr,
  input  logic               fifo_empty,
  input  logic               fifo_full,
  input  logic               done_pulse,
  input  logic               sel_pulse,
  input  logic               resel_pulse,
  input  logic               sel_en,
  input  logic               resel_en,
  input  logic               stat_rd,
  input  logic [ST_W-1:0]    irq_mask,
  output logic [ST_W-1:0]    int_status,
  output logic               irq
);
  localparam int SW = PHASE_W + 3;

  logic [SW-1:0]      sync_q, sync_p;
  logic [PHASE_W-1:0] phase_s, phase_p;
  logic               req_rise, ack_rise, atn_rise, phase_chg;
  logic [OFS_W-1:0]   ofs_cnt;
  logic               ev_ovf, ev_udf, ev_phs, ev_fifo, ev_mis;
  logic [ST_W-1:0]    ev_vec;

  xmon_sync #(.W(SW), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({~bus_atn_n, ~bus_ack_n, ~bus_req_n, bus_phase}),
    .q(sync_q), .q_prev(sync_p)
  );

  assign phase_s   = sync_q[PHASE_W-1:0];
  assign phase_p   = sync_p[PHASE_W-1:0];
  assign req_rise  = sync_q[PHASE_W]   & ~sync_p[PHASE_W];
  assign ack_rise  = sync_q[PHASE_W+1] & ~sync_p[PHASE_W+1];
  assign atn_rise  = sync_q[PHASE_W+2] & ~sync_p[PHASE_W+2];
  assign phase_chg = (phase_s != phase_p);

  xmon_offset #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst_n(rst_n),
    .req_rise(req_rise), .ack_rise(ack_rise), .phase_chg(phase_chg),
    .is_initiator(is_initiator), .max_offset(max_offset),
    .ofs_cnt(ofs_cnt), .ev_ovf(ev_ovf), .ev_udf(ev_udf), .ev_phs(ev_phs)
  );

  assign ev_fifo = (fifo_rd & fifo_empty) | (fifo_wr & fifo_full);
  assign ev_mis  = is_initiator ? (req_rise & (phase_s != exp_phase)) : atn_rise;

  always_comb begin
    ev_vec          = '0;
    ev_vec[B_PHASE] = ev_mis;
    ev_vec[B_DONE]  = done_pulse;
    ev_vec[B_SEL]   = sel_pulse & sel_en;
    ev_vec[B_RESEL] = resel_pulse & resel_en;
    ev_vec[B_GROSS] = ev_ovf | ev_udf | ev_phs | ev_fifo;
  end

  xmon_status #(.W(ST_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .rd(stat_rd), .stat(int_status)
  );

  assign irq = |(int_status & irq_mask);
endmodule

// File: rtl/xmon_checker.sv
module xmon_checker #(
  parameter int OFS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stat_rd,
  input logic [7:0]       ev_vec,
  input logic [7:0]       int_status,
  input logic             req_rise,
  input logic             ack_rise,
  input logic             is_initiator,
  input logic [OFS_W-1:0] ofs_cnt,
  input logic [OFS_W-1:0] max_offset,
  input logic             sel_pulse,
  input logic             sel_en
);
  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ev_vec == 8'h00) |=> int_status == 8'h00);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((int_status & $past(int_status)) == $past(int_status)));

  assert_event_latches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != 8'h00) |=> ((int_status & $past(ev_vec)) == $past(ev_vec)));

  assert_offset_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rise || ack_rise) |=> $stable(ofs_cnt));

  assert_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_initiator && ack_rise && !req_rise && ofs_cnt == '0) |=> int_status[3]);

  assert_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_initiator && req_rise && !ack_rise && max_offset != '0 && ofs_cnt >= max_offset)
    |=> int_status[3]);

  assert_sel_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pulse && !sel_en && (stat_rd || !int_status[5])) |=> !int_status[5]);
endmodule

bind scsi_xfer_monitor xmon_checker #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .ev_vec(ev_vec),
  .int_status(int_status), .req_rise(req_rise), .ack_rise(ack_rise),
  .is_initiator(is_initiator), .ofs_cnt(ofs_cnt), .max_offset(max_offset),
  .sel_pulse(sel_pulse), .sel_en(sel_en)
);

// File: tb/sim_scsi_xfer_monitor.sv
`timescale 1ns/1ps
module sim_scsi_xfer_monitor;
  logic clk = 0, rst_n = 0;
  logic bus_req_n = 1, bus_ack_n = 1, bus_atn_n = 1;
  logic [2:0] bus_phase = 0, exp_phase = 0;
  logic is_initiator = 1;
  logic [3:0] max_offset = 4;
  logic fifo_rd = 0, fifo_wr = 0, fifo_empty = 0, fifo_full = 0;
  logic done_pulse = 0, sel_pulse = 0, resel_pulse = 0, sel_en = 0, resel_en = 0;
  logic stat_rd = 0;
  logic [7:0] irq_mask = 8'hFF;
  logic [7:0] int_status;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  bit  reported = 0;

  always #2 clk = ~clk;

  scsi_xfer_monitor u0 (.*);

  // Behavioural reference: history of wire samples, integer offset.
  typedef struct { bit req; bit ack; bit atn; bit [2:0] ph; } smp_t;
  smp_t hist[$];
  int   m_ofs;
  bit [7:0] m_stat;

  always @(posedge clk) begin
    smp_t z, cur, old, now;
    bit rq, ak, at, pc, g, pm;
    bit [7:0] ev;
    if (!rst_n) begin
      z = '{req:0, ack:0, atn:0, ph:0};
      hist = {z, z, z};
      m_ofs = 0; m_stat = 0;
    end else begin
      cur = hist[1]; old = hist[0];
      rq = cur.req && !old.req;
      ak = cur.ack && !old.ack;
      at = cur.atn && !old.atn;
      pc = cur.ph != old.ph;
      g = (fifo_rd && fifo_empty) || (fifo_wr && fifo_full);
      if (is_initiator) begin
        if (rq && !ak && max_offset != 0 && m_ofs >= int'(max_offset)) g = 1;
        if (pc && m_ofs != 0) g = 1;
        pm = rq && (cur.ph != exp_phase);
      end else begin
        if (ak && !rq && m_ofs == 0) g = 1;
        pm = at;
      end
      if (rq && !ak && m_ofs < 15) m_ofs++;
      else if (ak && !rq && m_ofs > 0) m_ofs--;
      ev = {pm, done_pulse, sel_pulse && sel_en, resel_pulse && resel_en, g, 3'b000};
      m_stat = (stat_rd ? 8'h00 : m_stat) | ev;
      now = '{req:!bus_req_n, ack:!bus_ack_n, atn:!bus_atn_n, ph:bus_phase};
      void'(hist.pop_front());
      hist.push_back(now);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (int_status !== m_stat || irq !== |(m_stat & irq_mask)) begin
        n_bad++;
        $display("FAIL model R11 status=%h/irq=%b expected %h/%b",
                 int_status, irq, m_stat, |(m_stat & irq_mask));
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic req_p(); bus_req_n = 0; tick(2); bus_req_n = 1; tick(2); endtask
  task automatic ack_p(); bus_ack_n = 0; tick(2); bus_ack_n = 1; tick(2); endtask
  task automatic rd_p();  stat_rd = 1; tick(1); stat_rd = 0; tick(1); endtask
  task automatic settle(); tick(5); endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    tick(3);
    chk("R1 status", int_status, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rst_n = 1; tick(2);

    // R13 latency and R7 mismatch
    exp_phase = 1; bus_req_n = 0;
    tick(2); chk("R13 before edge k+2", int_status, 8'h00);
    tick(1); chk("R13 after edge k+2", int_status, 8'h80);
    bus_req_n = 1; tick(2); exp_phase = 0;
    ack_p(); settle(); rd_p(); chk("R11 read clears", int_status, 8'h00);

    // R3 overflow
    max_offset = 2;
    repeat (3) req_p();
    settle(); chk("R3 overflow", int_status, 8'h08);
    rd_p(); repeat (3) ack_p(); settle();
    chk("R2 balanced acks", int_status, 8'h00);

    // R3 async disables limit
    max_offset = 0;
    repeat (5) req_p();
    settle(); chk("R3 async no limit", int_status, 8'h00);
    repeat (5) ack_p(); settle();

    // R9 / R12
    done_pulse = 1; tick(1); done_pulse = 0; tick(1);
    chk("R9 done", int_status, 8'h40);
    irq_mask = 8'h40; tick(1); chk("R12 irq on", {7'b0, irq}, 8'h01);
    irq_mask = 8'hBF; tick(1); chk("R12 irq masked", {7'b0, irq}, 8'h00);
    irq_mask = 8'hFF; rd_p();

    // R10
    sel_pulse = 1; tick(1); sel_pulse = 0; tick(1);
    chk("R10 sel disabled", int_status, 8'h00);
    sel_en = 1; sel_pulse = 1; tick(1); sel_pulse = 0; tick(1);
    chk("R10 sel", int_status, 8'h20); rd_p();
    resel_pulse = 1; tick(1); resel_pulse = 0; tick(1);
    chk("R10 resel disabled", int_status, 8'h00);
    resel_en = 1; resel_pulse = 1; tick(1); resel_pulse = 0; tick(1);
    chk("R10 resel", int_status, 8'h10); rd_p();

    // R6
    fifo_empty = 1; fifo_rd = 1; tick(1); fifo_rd = 0; tick(1);
    chk("R6 read empty", int_status, 8'h08); rd_p();
    fifo_empty = 0; fifo_rd = 1; tick(1); fifo_rd = 0; tick(1);
    chk("R6 read ok", int_status, 8'h00);
    fifo_full = 1; fifo_wr = 1; tick(1); fifo_wr = 0; tick(1);
    chk("R6 write full", int_status, 8'h08); rd_p(); fifo_full = 0;

    // R11 event during read survives
    fifo_empty = 1; fifo_rd = 1; tick(1); fifo_rd = 0; tick(1);
    stat_rd = 1; done_pulse = 1; tick(1); stat_rd = 0; done_pulse = 0; tick(1);
    chk("R11 same-cycle event", int_status, 8'h40); rd_p(); fifo_empty = 0;

    // R5 phase change
    req_p(); bus_phase = 1; exp_phase = 1; settle();
    chk("R5 change with offset", int_status, 8'h08);
    ack_p(); rd_p(); bus_phase = 0; exp_phase = 0; settle();
    chk("R5 change at zero", int_status, 8'h00);

    // R7
    exp_phase = 2; req_p(); settle();
    chk("R7 mismatch", int_status, 8'h80);
    exp_phase = 0; ack_p(); rd_p();

    // R8 / R4 target
    is_initiator = 0; tick(1);
    bus_atn_n = 0; settle(); chk("R8 atn", int_status, 8'h80);
    bus_atn_n = 1; tick(2); rd_p();
    ack_p(); settle(); chk("R4 underflow", int_status, 8'h08); rd_p();
    req_p(); ack_p(); settle(); chk("R4 balanced", int_status, 8'h00);

    // R2 simultaneous edges leave count at zero
    bus_req_n = 0; bus_ack_n = 0; tick(2); bus_req_n = 1; bus_ack_n = 1; tick(2);
    settle(); chk("R2 simultaneous", int_status, 8'h00);
    ack_p(); settle(); chk("R2 count still zero", int_status, 8'h08); rd_p();

    // R2 saturation at 15
    is_initiator = 1; max_offset = 0; tick(1);
    repeat (17) req_p();
    repeat (14) ack_p();
    is_initiator = 0; tick(1);
    ack_p(); settle(); chk("R2 saturated at 15", int_status, 8'h00);
    ack_p(); settle(); chk("R2 reached zero", int_status, 8'h08); rd_p();

    tick(4);
    report();
  end
endmodule